// File: doc/BRIEF.md
# Multi-Dimensional Vector Element Index Remapper

This block turns the linear element position of a vector loop into a reordered element index for each of five operand slots: three sources (A, B, C) and two destinations (T, and U, which is the second write or address slot). Four programmable shapes are stored. Each shape has x, y and z extents, a loop nesting order and a base offset. Each slot uses one of the shapes or passes the plain linear position through. Because of this, the same register data can be walked transposed, repeated or from the middle without being copied.

A loop is launched with a length and a sub-vector factor. After that, every step strobe yields one registered set of slot indices. Each index carries an out-of-range flag, which is set when it reaches past the register file limit. A loop that was interrupted can be resumed from a saved linear position. The block rebuilds its shape counters internally before it accepts steps again. Each shape keeps x/y/z counters that advance in its chosen nesting order, so the hardware never divides.

Top module: `vec_index_remapper`

## Requirements
- R1: Configuration writes go through `cfg_addr`. Addresses 0..3 load shapes 0..3. Address 4 loads the slot map. A shape word holds the x extent minus one in bits [3:0], the y extent minus one in bits [7:4], the z extent minus one in bits [11:8], the nesting code in bits [14:12] and the offset in bits [23:16].
- R2: In the slot map word, the shape selector of slot s (A=0, B=1, C=2, T=3, U=4) sits in bits [2s+1:2s], and the enable for slot s sits in bit 10+s. A slot whose enable is clear outputs the linear position, with no offset added.
- R3: An enabled slot outputs x + y·X + z·X·Y, where X and Y are the x and y extents. The counters advance innermost first, in the order given by the nesting code. The codes are: 0 = x,y,z; 1 = x,z,y; 2 = y,x,z; 3 = y,z,x; 4 = z,x,y; 5 = z,y,x (innermost listed first); 6 and 7 behave as code 0. For example, a 4×4 shape with code 2 yields 0,4,8,12,1,5,…, and a 4×1 shape with code 0 yields 0,1,2,3,0,1,….
- R4: A shape whose total element count X·Y·Z is smaller than the loop length wraps back to its first index and repeats the sequence.
- R5: Code 0 yields the linear position modulo the shape total. A shape with at least two extents equal to one yields the same sequence under every nesting code.
- R6: The selected shape's offset is added to the computed index of an enabled slot.
- R7: A resume pulse with saved position p starts a loop from position p. Steps are honoured from the (p+2)-th clock edge after the resume edge onward, and the first honoured step outputs the indices of position p.
- R8: `idx_illegal` for a slot is set with that slot's index exactly when the index is at least REG_LIMIT (default 128).
- R9: The loop length is vl·(subvl+1), where `subvl` holds the sub-vector size minus one. Element i, sub-element j takes linear position i·(subvl+1)+j.
- R10: Configuration writes made while `busy` is high are ignored. The running loop and later loops keep the old configuration.
- R11: A step accepted at one clock edge updates the indices and pulses `idx_valid` at that same edge. The step at the last position also pulses `done` and drops `busy`.
- R12: After reset, all outputs are zero. A step strobe while no loop is active produces no `idx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration target: 0..3 shapes, 4 slot map |
| cfg_wdata | input | 24 | Configuration word |
| start | input | 1 | Launch a loop from position 0 |
| resume | input | 1 | Launch a loop from `resume_pos` |
| resume_pos | input | 10 | Saved linear position for resume |
| vl | input | 8 | Loop element count |
| subvl | input | 2 | Sub-vector size minus one |
| step | input | 1 | Advance one position |
| busy | output | 1 | A loop is seeking or running |
| idx_valid | output | 1 | Indices updated by an accepted step |
| done | output | 1 | The last position was output |
| idx_out | output | 65 | Five 13-bit slot indices, slot A in the low bits |
| idx_illegal | output | 5 | Per-slot out-of-range flag |

## Verification
An accepted step is visible after the same rising edge that samples it. The bench therefore raises `step` at a falling edge, lowers it at the next falling edge and reads all five slot indices, the flags, `done` and `busy` there. A resume needs p+1 edges to rebuild the counters, so the bench waits a few edges beyond the p+2 edges of R7 before its first step. Configuration writes take effect at the edge that samples them. Every slot index is compared with a bench model that decomposes the position by integer division in the nesting order, which is a different route from the hardware counters.

// File: rtl/remap_pkg.sv
package remap_pkg;
  parameter int DIMW    = 4;
  parameter int PERMW   = 3;
  parameter int OFFW    = 8;
  parameter int NSHAPE  = 4;
  parameter int NSLOT   = 5;
  parameter int SELW    = 2;
  parameter int OFF_LSB = 16;

  localparam int LW   = 3 * DIMW;
  localparam int IW   = LW + 1;
  localparam int CFGW = OFF_LSB + OFFW;
  localparam int EN_LSB = NSLOT * SELW;

  typedef struct packed {
    logic [OFFW-1:0]  offset;
    logic [PERMW-1:0] perm;
    logic [DIMW-1:0]  zd;
    logic [DIMW-1:0]  yd;
    logic [DIMW-1:0]  xd;
  } shape_t;

  // returns {outer, middle, inner} axis numbers, 0=x 1=y 2=z
  function automatic logic [5:0] perm_order(input logic [PERMW-1:0] code);
    case (code)
      3'd1:    perm_order = {2'd1, 2'd2, 2'd0};
      3'd2:    perm_order = {2'd2, 2'd0, 2'd1};
      3'd3:    perm_order = {2'd0, 2'd2, 2'd1};
      3'd4:    perm_order = {2'd1, 2'd0, 2'd2};
      3'd5:    perm_order = {2'd0, 2'd1, 2'd2};
      default: perm_order = {2'd2, 2'd1, 2'd0};
    endcase
  endfunction
endpackage

// File: rtl/remap_shape_walker.sv
module remap_shape_walker
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [DIMW-1:0]  xd,
  input  logic [DIMW-1:0]  yd,
  input  logic [DIMW-1:0]  zd,
  input  logic [PERMW-1:0] perm,
  output logic [LW-1:0]    lidx
);
  logic [2:0][DIMW-1:0] cnt_q, cnt_d, dim;
  logic [5:0] ord;
  logic       carry;
  logic [1:0] ax;
  logic [LW-1:0] ex, ey, ez, wx, wxy;

  assign dim = {zd, yd, xd};
  assign ord = perm_order(perm);

  // ripple the increment from the innermost axis outward
  always_comb begin
    cnt_d = cnt_q;
    carry = 1'b1;
    ax    = 2'd0;
    for (int k = 0; k < 3; k++) begin
      ax = ord[2*k +: 2];
      if (carry) begin
        if (cnt_q[ax] == dim[ax]) begin
          cnt_d[ax] = '0;
        end else begin
          cnt_d[ax] = cnt_q[ax] + 1'b1;
          carry     = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (adv)   cnt_q <= cnt_d;
  end

  assign ex   = LW'(cnt_q[0]);
  assign ey   = LW'(cnt_q[1]);
  assign ez   = LW'(cnt_q[2]);
  assign wx   = LW'(xd) + LW'(1);
  assign wxy  = wx * (LW'(yd) + LW'(1));
  assign lidx = ex + ey * wx + ez * wxy;
endmodule

// File: rtl/remap_sequencer.sv
module remap_sequencer #(
  parameter int VLW  = 8,
  parameter int LINW = VLW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            resume,
  input  logic [LINW-1:0] resume_pos,
  input  logic [VLW-1:0]  vl,
  input  logic [1:0]      subvl,
  input  logic            step,
  output logic            busy,
  output logic            fire,
  output logic            adv,
  output logic            clr,
  output logic            last,
  output logic [LINW-1:0] lin
);
  typedef enum logic [1:0] {S_IDLE, S_SEEK, S_RUN} state_t;
  state_t state;
  logic [LINW-1:0] len_q, tgt_q, len_in;
  logic seek_adv;

  assign len_in   = LINW'(vl) * (LINW'(subvl) + LINW'(1));
  assign seek_adv = (state == S_SEEK) && (lin != tgt_q);
  assign clr      = start || resume;
  assign fire     = (state == S_RUN) && step && !clr;
  assign adv      = fire || seek_adv;
  assign last     = fire && (lin == len_q - LINW'(1));
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      lin   <= '0;
      len_q <= '0;
      tgt_q <= '0;
    end else if (start) begin
      lin   <= '0;
      len_q <= len_in;
      state <= (len_in == '0) ? S_IDLE : S_RUN;
    end else if (resume) begin
      lin   <= '0;
      len_q <= len_in;
      tgt_q <= resume_pos;
      state <= (resume_pos < len_in) ? S_SEEK : S_IDLE;
    end else begin
      case (state)
        S_SEEK: begin
          if (lin == tgt_q) state <= S_RUN;
          else              lin   <= lin + LINW'(1);
        end
        S_RUN: begin
          if (step) begin
            lin <= lin + LINW'(1);
            if (lin == len_q - LINW'(1)) state <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vec_index_remapper.sv
module vec_index_remapper
  import remap_pkg::*;
#(
  parameter  int VLW       = 8,
  parameter  int REG_LIMIT = 128,
  parameter  int CFG_AW    = 3,
  localparam int LINW      = VLW + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFGW-1:0]       cfg_wdata,
  input  logic                  start,
  input  logic                  resume,
  input  logic [LINW-1:0]       resume_pos,
  input  logic [VLW-1:0]        vl,
  input  logic [1:0]            subvl,
  input  logic                  step,
  output logic                  busy,
  output logic                  idx_valid,
  output logic                  done,
  output logic [NSLOT*IW-1:0]   idx_out,
  output logic [NSLOT-1:0]      idx_illegal
);
  shape_t [NSHAPE-1:0]           shape_q;
  logic   [NSLOT-1:0][SELW-1:0]  sel_q;
  logic   [NSLOT-1:0]            en_q;
  logic   [NSHAPE-1:0][LW-1:0]   lidx_all;
  logic   [NSLOT-1:0][IW-1:0]    raw, idx_q;
  logic   [NSLOT-1:0]            ill_q;
  logic fire, adv, clr, last;
  logic [LINW-1:0] lin;
  shape_t wr_shape;

  assign wr_shape.xd     = cfg_wdata[DIMW-1:0];
  assign wr_shape.yd     = cfg_wdata[2*DIMW-1:DIMW];
  assign wr_shape.zd     = cfg_wdata[3*DIMW-1:2*DIMW];
  assign wr_shape.perm   = cfg_wdata[3*DIMW+PERMW-1:3*DIMW];
  assign wr_shape.offset = cfg_wdata[OFF_LSB+OFFW-1:OFF_LSB];

  // configuration is frozen while a loop is seeking or running
  always_ff @(posedge clk) begin
    if (rst) begin
      shape_q <= '0;
      sel_q   <= '0;
      en_q    <= '0;
    end else if (cfg_we && !busy) begin
      if (cfg_addr < CFG_AW'(NSHAPE)) begin
        shape_q[cfg_addr[SELW-1:0]] <= wr_shape;
      end else if (cfg_addr == CFG_AW'(NSHAPE)) begin
        sel_q <= cfg_wdata[EN_LSB-1:0];
        en_q  <= cfg_wdata[EN_LSB+NSLOT-1:EN_LSB];
      end
    end
  end

  remap_sequencer #(.VLW(VLW), .LINW(LINW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .resume(resume),
    .resume_pos(resume_pos), .vl(vl), .subvl(subvl), .step(step),
    .busy(busy), .fire(fire), .adv(adv), .clr(clr), .last(last), .lin(lin)
  );

  for (genvar g = 0; g < NSHAPE; g++) begin : g_shape
    remap_shape_walker u_walk (
      .clk(clk), .rst(rst), .clr(clr), .adv(adv),
      .xd(shape_q[g].xd), .yd(shape_q[g].yd), .zd(shape_q[g].zd),
      .perm(shape_q[g].perm), .lidx(lidx_all[g])
    );
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_comb begin
      if (en_q[s])
        raw[s] = IW'(lidx_all[sel_q[s]]) + IW'(shape_q[sel_q[s]].offset);
      else
        raw[s] = IW'(lin);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[s] <= '0;
        ill_q[s] <= 1'b0;
      end else if (fire) begin
        idx_q[s] <= raw[s];
        ill_q[s] <= (raw[s] >= IW'(REG_LIMIT));
      end
    end

    assign idx_out[s*IW +: IW] = idx_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      idx_valid <= fire;
      done      <= last;
    end
  end

  assign idx_illegal = ill_q;
endmodule

// File: rtl/remap_checker.sv
module remap_checker
  import remap_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic start,
  input logic resume,
  input logic busy,
  input logic idx_valid,
  input logic done,
  input logic [NSHAPE*$bits(shape_t)-1:0] shapes,
  input logic [NSLOT*SELW-1:0]            sels,
  input logic [NSLOT-1:0]                 ens
);
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(shapes) && $stable(sels) && $stable(ens)));

  a_r11_done_with_valid: assert property (@(posedge clk) disable iff (rst)
    done |-> idx_valid);

  a_r11_done_ends_loop: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r12_valid_needs_loop: assert property (@(posedge clk) disable iff (rst)
    idx_valid |-> $past(busy));

  a_r7_launch_no_output: assert property (@(posedge clk) disable iff (rst)
    (start || resume) |=> !idx_valid);
endmodule

bind vec_index_remapper remap_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .resume(resume), .busy(busy),
  .idx_valid(idx_valid), .done(done), .shapes(shape_q), .sels(sel_q), .ens(en_q)
);

// File: tb/vec_index_remapper_bench.sv
module vec_index_remapper_bench;
  import remap_pkg::*;
  localparam int VLW = 8;
  localparam int LINW = VLW + 2;
  localparam int LIMIT = 128;

  logic clk = 1'b0;
  logic rst, cfg_we, start, resume, step;
  logic [2:0] cfg_addr;
  logic [CFGW-1:0] cfg_wdata;
  logic [LINW-1:0] resume_pos;
  logic [VLW-1:0] vl;
  logic [1:0] subvl;
  logic busy, idx_valid, done;
  logic [NSLOT*IW-1:0] idx_out;
  logic [NSLOT-1:0] idx_illegal;

  int errors = 0;
  int checks = 0;
  int m_xd[4], m_yd[4], m_zd[4], m_pm[4], m_off[4];
  int m_sel[5], m_en[5];

  always #10 clk = ~clk;

  vec_index_remapper u_vec_index_remapper (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .resume(resume), .resume_pos(resume_pos), .vl(vl), .subvl(subvl),
    .step(step), .busy(busy), .idx_valid(idx_valid), .done(done),
    .idx_out(idx_out), .idx_illegal(idx_illegal)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_local(input int sh, input int n);
    int sz[3]; int c[3]; int o0, o1, o2, tot, p;
    sz[0] = m_xd[sh] + 1; sz[1] = m_yd[sh] + 1; sz[2] = m_zd[sh] + 1;
    case (m_pm[sh])
      1: begin o0 = 0; o1 = 2; o2 = 1; end
      2: begin o0 = 1; o1 = 0; o2 = 2; end
      3: begin o0 = 1; o1 = 2; o2 = 0; end
      4: begin o0 = 2; o1 = 0; o2 = 1; end
      5: begin o0 = 2; o1 = 1; o2 = 0; end
      default: begin o0 = 0; o1 = 1; o2 = 2; end
    endcase
    tot = sz[0] * sz[1] * sz[2];
    p = n % tot;
    c[o0] = p % sz[o0];
    c[o1] = (p / sz[o0]) % sz[o1];
    c[o2] = p / (sz[o0] * sz[o1]);
    return c[0] + c[1] * sz[0] + c[2] * sz[0] * sz[1];
  endfunction

  function automatic int ref_slot(input int s, input int n);
    if (m_en[s] != 0) return ref_local(m_sel[s], n) + m_off[m_sel[s]];
    return n;
  endfunction

  task automatic cfg_shape(input int sh, input int xd, input int yd, input int zd,
                           input int pm, input int off, input bit upd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(sh);
    cfg_wdata = {8'(off), 1'b0, 3'(pm), 4'(zd), 4'(yd), 4'(xd)};
    @(negedge clk);
    cfg_we = 1'b0;
    if (upd) begin
      m_xd[sh] = xd; m_yd[sh] = yd; m_zd[sh] = zd; m_pm[sh] = pm; m_off[sh] = off;
    end
  endtask

  task automatic cfg_map(input int a, input int b, input int c, input int t, input int u,
                         input int en, input bit upd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd4;
    cfg_wdata = {9'd0, 5'(en), 2'(u), 2'(t), 2'(c), 2'(b), 2'(a)};
    @(negedge clk);
    cfg_we = 1'b0;
    if (upd) begin
      m_sel[0] = a; m_sel[1] = b; m_sel[2] = c; m_sel[3] = t; m_sel[4] = u;
      for (int s = 0; s < 5; s++) m_en[s] = (en >> s) & 1;
    end
  endtask

  task automatic step_check(input int n, input int total, input string req);
    int e;
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk("R11", "idx_valid", int'(idx_valid), 1);
    for (int s = 0; s < 5; s++) begin
      e = ref_slot(s, n);
      chk(req, $sformatf("slot%0d pos%0d idx", s, n), int'(idx_out[s*IW +: IW]), e);
      chk("R8", $sformatf("slot%0d pos%0d illegal", s, n), int'(idx_illegal[s]),
          (e >= LIMIT) ? 1 : 0);
    end
    chk("R11", "done", int'(done), (n == total - 1) ? 1 : 0);
    chk("R11", "busy", int'(busy), (n == total - 1) ? 0 : 1);
  endtask

  task automatic launch(input int v, input int sv);
    @(negedge clk);
    start = 1'b1; vl = 8'(v); subvl = 2'(sv);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_loop(input int v, input int sv, input string req);
    int total;
    total = v * (sv + 1);
    launch(v, sv);
    for (int n = 0; n < total; n++) step_check(n, total, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; start = 1'b0;
    resume = 1'b0; resume_pos = '0; vl = '0; subvl = '0; step = 1'b0;
    for (int i = 0; i < 4; i++) begin
      m_xd[i] = 0; m_yd[i] = 0; m_zd[i] = 0; m_pm[i] = 0; m_off[i] = 0;
    end
    for (int s = 0; s < 5; s++) begin m_sel[s] = 0; m_en[s] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state and idle step
    chk("R12", "busy after reset", int'(busy), 0);
    chk("R12", "valid after reset", int'(idx_valid), 0);
    chk("R12", "done after reset", int'(done), 0);
    chk("R12", "idx_out after reset", int'(idx_out != '0), 0);
    chk("R12", "illegal after reset", int'(idx_illegal), 0);
    @(negedge clk); step = 1'b1;
    @(negedge clk); step = 1'b0;
    chk("R12", "valid on idle step", int'(idx_valid), 0);

    // R1 R3 transposed 4x4 on A, cycling 4x1 on B, C unshaped
    cfg_shape(0, 3, 3, 0, 2, 0, 1'b1);
    cfg_shape(1, 3, 0, 0, 0, 0, 1'b1);
    cfg_map(0, 1, 0, 1, 0, 5'b01011, 1'b1);
    run_loop(16, 0, "R3");

    // R4 wrap: total 6 under nesting y,z,x over 15 steps; R2 disabled slots
    cfg_shape(2, 2, 1, 0, 3, 0, 1'b1);
    cfg_shape(3, 1, 1, 1, 4, 0, 1'b1);
    cfg_map(2, 3, 2, 0, 3, 5'b10011, 1'b1);
    run_loop(15, 0, "R4");

    // R5 identity code with wrap, and two unit extents under code 5
    cfg_shape(0, 2, 2, 0, 0, 0, 1'b1);
    cfg_shape(1, 0, 5, 0, 5, 0, 1'b1);
    cfg_map(0, 1, 1, 0, 0, 5'b00111, 1'b1);
    run_loop(20, 0, "R5");

    // R6 offset and R8 limit crossing
    cfg_shape(2, 15, 0, 0, 0, 120, 1'b1);
    cfg_shape(3, 3, 1, 0, 2, 9, 1'b1);
    cfg_map(2, 3, 2, 3, 0, 5'b01111, 1'b1);
    run_loop(16, 0, "R6");

    // R9 sub-vectors: 5 elements of 3
    cfg_shape(0, 2, 4, 0, 2, 0, 1'b1);
    cfg_map(0, 0, 1, 0, 0, 5'b00001, 1'b1);
    run_loop(5, 2, "R9");

    // R7 resume from position 7 of 16
    cfg_shape(0, 3, 3, 0, 2, 2, 1'b1);
    cfg_shape(1, 1, 1, 3, 1, 0, 1'b1);
    cfg_map(0, 1, 0, 1, 0, 5'b11011, 1'b1);
    @(negedge clk);
    resume = 1'b1; resume_pos = 10'd7; vl = 8'd16; subvl = 2'd0;
    @(negedge clk);
    resume = 1'b0;
    chk("R7", "busy while seeking", int'(busy), 1);
    repeat (10) @(negedge clk);
    chk("R7", "no output before first step", int'(idx_valid), 0);
    for (int n = 7; n < 16; n++) step_check(n, 16, "R7");

    // R10 writes during a loop are ignored
    cfg_shape(0, 3, 1, 0, 2, 0, 1'b1);
    cfg_map(0, 0, 0, 0, 0, 5'b00001, 1'b1);
    launch(8, 0);
    for (int n = 0; n < 3; n++) step_check(n, 8, "R10");
    cfg_shape(0, 7, 0, 0, 0, 50, 1'b0);
    cfg_map(1, 1, 1, 1, 1, 5'b00000, 1'b0);
    for (int n = 3; n < 8; n++) step_check(n, 8, "R10");
    run_loop(8, 0, "R10");

    // R3 randomized shapes, maps and lengths
    void'($urandom(32'd7321));
    for (int it = 0; it < 15; it++) begin
      for (int sh = 0; sh < 4; sh++)
        cfg_shape(sh, $urandom_range(3), $urandom_range(3), $urandom_range(3),
                  $urandom_range(7), $urandom_range(70), 1'b1);
      cfg_map($urandom_range(3), $urandom_range(3), $urandom_range(3),
              $urandom_range(3), $urandom_range(3), $urandom_range(31), 1'b1);
      run_loop($urandom_range(24, 1), $urandom_range(3), "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule